// File: doc/BRIEF.md
# Endian-Configurable Byte Memory Port

This block is a load/store port that sits between a processor and a small byte-addressed memory, which is held inside the block. Each request gives a byte address, an access size (one, two, four or eight bytes), a read/write select and a byte-order select.

On a store, the register value is split into bytes. Those bytes are written to consecutive byte addresses, starting at the request address. The byte-order select decides whether the low-order or the high-order byte lands at the lowest address. On a load, the same number of bytes is read back and put together again under the chosen order. The result is right-justified in a 64-bit result and zero-extended above the access width.

Every request is checked against its size. A request whose address is not a multiple of its access size is refused: a one-cycle error pulse is raised and the memory is left untouched.

Top module: `endian_mem_port`

## Requirements
- R1: With `req_big`=0 (little-endian), a store of N bytes puts bit-byte k of `req_wdata` (bits 8k+7..8k) at byte address `req_addr`+k. Example: the 32-bit value 0x46789654 stored at address A gives 0x54, 0x96, 0x78, 0x46 at A..A+3.
- R2: With `req_big`=1 (big-endian), a store of N bytes puts byte k of `req_wdata` at address `req_addr`+N-1-k. The most significant byte of the access therefore goes to the lowest address.
- R3: A little-endian load returns the byte at `req_addr`+k in bits 8k+7..8k of `rd_data`.
- R4: A big-endian load returns the byte at `req_addr` as the most significant byte of the N-byte result.
- R5: `req_size` encodes 0=8 bits, 1=16 bits, 2=32 bits and 3=64 bits. An access is misaligned when its address is not a multiple of 2, 4 or 8 for sizes 1, 2 and 3. Byte accesses are never misaligned.
- R6: A misaligned request sets `misalign_err` for exactly the one cycle after the request. It writes no byte, and it gives no `rd_vld`.
- R7: For an aligned load, `rd_vld` is high for exactly the one cycle after the request, and `rd_data` holds the result in that cycle.
- R8: A load of fewer than 8 bytes zero-fills `rd_data` above the access width.
- R9: A load changes no memory byte. A store changes only its own N bytes and leaves neighbouring bytes as they were.
- R10: The value of `req_big` has no effect on byte-sized (size 0) stores or loads.
- R11: While `rst_n` is low, and after it is released, `rd_vld`, `misalign_err` and `rd_data` are 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one cycle per access |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_size | input | 2 | Access size: 0=byte, 1=half, 2=word, 3=double |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Store value, right-justified |
| rd_data | output | 64 | Load result, right-justified and zero-extended |
| rd_vld | output | 1 | Load result valid, one cycle after the request |
| misalign_err | output | 1 | Misaligned request refused, one cycle after it |

## Verification
The hardest case to observe from the ports is a refused store, because nothing at the outputs changes except the error pulse. The stimulus first fills a region with a known word. It then issues a misaligned word store that overlaps the region, and reads the region back to show that every byte survived. A similar blind spot is a byte store next to untouched bytes. To cover it, a region is zeroed with a double store, then one byte inside it is rewritten with a store value whose upper bytes are all ones. A wider load of the region then exposes any extra lane that was written.

// File: rtl/emp_pkg.sv
package emp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;
endpackage

// File: rtl/emp_align_chk.sv
module emp_align_chk #(
  parameter int ADDR_W = 6
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  logic [2:0] low_mask;

  always_comb begin
    low_mask   = 3'((1 << size) - 1);
    misaligned = |(addr[2:0] & low_mask);
  end
endmodule

// File: rtl/emp_lane_map.sv
module emp_lane_map #(
  parameter int LANES = 8,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [1:0]                  size,
  input  logic                        big,
  output logic [LANES-1:0]            lane_on,
  output logic [LANES-1:0][IDX_W-1:0] sig_idx
);
  int nbytes;

  always_comb nbytes = 1 << size;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      lane_on[k] = (k < nbytes);
      if (big) sig_idx[k] = IDX_W'(nbytes - 1 - k);
      else     sig_idx[k] = IDX_W'(k);
    end
  end
endmodule

// File: rtl/emp_byte_ram.sv
module emp_byte_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic [ADDR_W-1:0]     base,
  input  logic [LANES-1:0]      we,
  input  logic [LANES-1:0][7:0] wbytes,
  output logic [LANES-1:0][7:0] rbytes
);
  logic [7:0] mem [DEPTH];

  for (genvar k = 0; k < LANES; k++) begin : g_port
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = base + ADDR_W'(k);
    assign rbytes[k] = mem[lane_addr];

    always_ff @(posedge clk) begin
      if (we[k]) mem[lane_addr] <= wbytes[k];
    end
  end
endmodule

// File: rtl/endian_mem_port.sv
module endian_mem_port #(
  parameter int ADDR_W = 6,
  localparam int DATA_W = 64,
  localparam int LANES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              req_wr,
  input  logic              req_big,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              misalign_err
);
  import emp_pkg::*;

  logic                        mis;
  logic [LANES-1:0]            lane_on;
  logic [LANES-1:0][IDX_W-1:0] sig_idx;
  logic [LANES-1:0]            we;
  logic [LANES-1:0][7:0]       wbytes;
  logic [LANES-1:0][7:0]       rbytes;
  logic [DATA_W-1:0]           rd_data_d;
  logic                        rd_vld_d, err_d, rd_en;

  emp_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .size(req_size), .addr(req_addr), .misaligned(mis)
  );

  emp_lane_map #(.LANES(LANES)) u_map (
    .size(req_size), .big(req_big), .lane_on(lane_on), .sig_idx(sig_idx)
  );

  emp_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ram (
    .clk(clk), .base(req_addr), .we(we), .wbytes(wbytes), .rbytes(rbytes)
  );

  // store path: memory lane k takes the register byte of its significance
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      wbytes[k] = req_wdata[int'(sig_idx[k])*8 +: 8];
      we[k]     = req_vld && req_wr && !mis && lane_on[k];
    end
  end

  // load path: lane k lands at its significance, unused bytes stay zero
  always_comb begin
    rd_data_d = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_on[k]) rd_data_d[int'(sig_idx[k])*8 +: 8] = rbytes[k];
    end
  end

  always_comb begin
    rd_en    = req_vld && !req_wr && !mis;
    rd_vld_d = rd_en;
    err_d    = req_vld && mis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld       <= 1'b0;
      misalign_err <= 1'b0;
    end else begin
      rd_vld       <= rd_vld_d;
      misalign_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_data_d;
  end

  AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_size == SZ_HALF) && req_addr[0]) |=> misalign_err); // R5
  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_size == SZ_WORD) && (req_addr[1:0] != 2'b00)) |=> misalign_err); // R5
  AST_BYTE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_size == SZ_BYTE)) |=> !misalign_err); // R10
  AST_ERR_NO_RDVLD: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_err |-> !rd_vld); // R6
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mis) |-> (we == '0)); // R6
  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |-> (we == '0)); // R9
  AST_RDVLD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr && (req_size == SZ_DBL) && (req_addr[2:0] == 3'd0)) |=> rd_vld); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rd_vld && !misalign_err)); // R7
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && ($past(req_size) == SZ_BYTE)) |-> (rd_data[DATA_W-1:8] == '0)); // R8
endmodule

// File: tb/endian_mem_port_test.sv
module endian_mem_port_test;
  localparam int ADDR_W = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_wr, req_big;
  logic [1:0]  req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [63:0] req_wdata;
  logic [63:0] rd_data;
  logic        rd_vld, misalign_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  endian_mem_port #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_big(req_big), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .rd_vld(rd_vld),
    .misalign_err(misalign_err)
  );

  typedef struct packed {
    logic [31:0] tag;
    logic        wr;
    logic        big;
    logic [1:0]  sz;
    logic [5:0]  addr;
    logic [63:0] data;
    logic        err;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{"R1", 1'b1, 1'b0, 2'd2, 6'h20, 64'h46789654, 1'b0, 64'h0},
    '{"R1", 1'b0, 1'b0, 2'd0, 6'h20, 64'h0, 1'b0, 64'h54},
    '{"R1", 1'b0, 1'b0, 2'd0, 6'h23, 64'h0, 1'b0, 64'h46},
    '{"R3", 1'b0, 1'b0, 2'd2, 6'h20, 64'h0, 1'b0, 64'h46789654},
    '{"R4", 1'b0, 1'b1, 2'd2, 6'h20, 64'h0, 1'b0, 64'h54967846},
    '{"R9", 1'b1, 1'b0, 2'd3, 6'h10, 64'h0, 1'b0, 64'h0},
    '{"R2", 1'b1, 1'b1, 2'd1, 6'h10, 64'hABCD, 1'b0, 64'h0},
    '{"R2", 1'b0, 1'b0, 2'd0, 6'h10, 64'h0, 1'b0, 64'hAB},
    '{"R10", 1'b0, 1'b1, 2'd0, 6'h11, 64'h0, 1'b0, 64'hCD},
    '{"R3", 1'b0, 1'b0, 2'd1, 6'h10, 64'h0, 1'b0, 64'hCDAB},
    '{"R1", 1'b1, 1'b0, 2'd3, 6'h08, 64'h0123456789ABCDEF, 1'b0, 64'h0},
    '{"R4", 1'b0, 1'b1, 2'd3, 6'h08, 64'h0, 1'b0, 64'hEFCDAB8967452301},
    '{"R8", 1'b0, 1'b0, 2'd1, 6'h0E, 64'h0, 1'b0, 64'h0123},
    '{"R6", 1'b1, 1'b0, 2'd2, 6'h22, 64'hDEADBEEF, 1'b1, 64'h0},
    '{"R6", 1'b0, 1'b0, 2'd2, 6'h20, 64'h0, 1'b0, 64'h46789654},
    '{"R5", 1'b0, 1'b0, 2'd1, 6'h21, 64'h0, 1'b1, 64'h0},
    '{"R5", 1'b0, 1'b0, 2'd3, 6'h04, 64'h0, 1'b1, 64'h0},
    '{"R10", 1'b1, 1'b1, 2'd0, 6'h13, 64'hFFFFFFFFFFFFFF5A, 1'b0, 64'h0},
    '{"R9", 1'b0, 1'b0, 2'd2, 6'h10, 64'h0, 1'b0, 64'h5A00CDAB}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic big, input logic [1:0] sz,
                       input logic [5:0] addr, input logic [63:0] data);
    @(negedge clk);
    req_vld = 1'b1; req_wr = wr; req_big = big; req_size = sz;
    req_addr = addr; req_wdata = data;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0; req_wdata = '1;
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_wr = 1'b0; req_big = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared during reset
    check("R11 rd_vld", 64'(rd_vld), 64'h0);
    check("R11 err", 64'(misalign_err), 64'h0);
    check("R11 rd_data", rd_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rd_vld after release", 64'(rd_vld), 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].wr, VECS[i].big, VECS[i].sz, VECS[i].addr, VECS[i].data);
      // one edge after the request: err / rd_vld / rd_data
      check($sformatf("%s vec%0d err", VECS[i].tag, i), 64'(misalign_err), 64'(VECS[i].err));
      check($sformatf("%s vec%0d rd_vld", VECS[i].tag, i), 64'(rd_vld),
            64'(!VECS[i].wr && !VECS[i].err));
      if (!VECS[i].wr && !VECS[i].err)
        check($sformatf("%s vec%0d data", VECS[i].tag, i), rd_data, VECS[i].exp);
      @(negedge clk);
      // R7 / R6: single-cycle pulses
      check($sformatf("R7 vec%0d pulse", i), 64'({rd_vld, misalign_err}), 64'h0);
    end

    // R6: misaligned double store over known data leaves it intact
    issue(1'b1, 1'b0, 2'd3, 6'h0C, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R6 dbl store refused", 64'(misalign_err), 64'h1);
    issue(1'b0, 1'b0, 2'd3, 6'h08, 64'h0);
    check("R6 dbl data intact", rd_data, 64'h0123456789ABCDEF);

    // R10: byte store with each mode gives same placement
    issue(1'b1, 1'b0, 2'd0, 6'h30, 64'h77);
    issue(1'b1, 1'b1, 2'd0, 6'h31, 64'h88);
    issue(1'b0, 1'b0, 2'd1, 6'h30, 64'h0);
    check("R10 byte modes", rd_data, 64'h8877);

    // R9: repeated load returns same value
    issue(1'b0, 1'b1, 2'd1, 6'h30, 64'h0);
    check("R9 load unchanged", rd_data, 64'h7788);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule